// File: doc/BRIEF.md
# Bunch-Synchronous Turn Intensity Capture

This block sits behind a 12-bit intensity digitiser that delivers one sample per bunch crossing on the bunch clock. A separate orbit pulse marks the first crossing of every accelerator turn. The block keeps a running bunch index inside the turn. It removes a programmable pedestal from each sample and zeroes any result that falls below a programmable cut, so that noise and cable reflections read as empty buckets. It also drives a reduced-resolution live intensity word on every crossing.

On a one-cycle trigger from the control side, the block arms itself. At the next orbit pulse it stores every crossing of exactly one turn into an internal FIFO, tagged with its bunch index. Software later drains the FIFO as pairs of 16-bit words. A busy flag covers the whole window from arming until the last entry has been written. A sticky overflow flag shows whether the FIFO ran out of space.

Top module: `turn_intensity_capture`

## Requirements
- R1: The crossing sampled while `orbitIn` is high has index 0. Each later crossing has an index one higher. The crossing with index `turnLen`-1 closes the turn, even when no orbit pulse follows it.
- R2: The corrected intensity is `sampleIn - baseline` when `sampleIn` exceeds `baseline`, and 0 otherwise. A corrected value strictly below `threshold` is replaced by 0. A value equal to `threshold` is kept.
- R3: `liveOut` shows the corrected intensity of a crossing one clock after that crossing is sampled. With `liveNarrow`=0 it carries corrected bits [9:2], and it reads 255 when the corrected value is 1024 or more. With `liveNarrow`=1 it carries corrected bits [9:6] in its low four bits, with the upper four bits zero, and it reads 15 when the corrected value is 1024 or more.
- R4: A `trigIn` pulse while idle arms a capture, and `busy` is high on the next clock. The capture starts at the next crossing that has `orbitIn` high. An orbit pulse in the same cycle as the trigger does not start it.
- R5: A capture stores one entry per crossing, for indices 0 through `turnLen`-1 in order, with the sample values of that turn, and then stops.
- R6: Each entry reads out as two words. The first word is {index[11:0], value[11:8]}. The second word is {first, last, suppressed, 5'b0, value[7:0]}. The flag first marks index 0. The flag last marks the entry that closes the turn. The flag suppressed is set when the sample exceeded the baseline but was zeroed by the threshold. `fifoData` shows the current word, and each `fifoRd` cycle advances one word.
- R7: `busy` falls only after the last entry is written into the FIFO. A `trigIn` pulse while a capture is armed or running is ignored.
- R8: An entry that arrives when the FIFO already holds FIFO_DEPTH entries is dropped, and `overflow` goes high. `overflow` stays high until the next accepted trigger, and the entries written before the overflow remain intact.
- R9: `fifoEmpty` is high when no entry is stored. A `fifoRd` while the FIFO is empty has no effect.
- R10: After reset, `liveOut` is 0, `busy` and `overflow` are low, and `fifoEmpty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock, one crossing per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | 12 | Digitised intensity of the current crossing |
| orbitIn | input | 1 | High on the first crossing of a turn |
| trigIn | input | 1 | One-cycle capture request |
| turnLen | input | 12 | Crossings per turn |
| baseline | input | 12 | Pedestal removed from each sample |
| threshold | input | 12 | Minimum corrected value kept |
| liveNarrow | input | 1 | 0: 8-bit live word, 1: 4-bit live word |
| liveOut | output | 8 | Live reduced intensity |
| fifoRd | input | 1 | Advance the readout by one word |
| fifoData | output | 16 | Current readout word (0 when empty) |
| fifoEmpty | output | 1 | No entry stored |
| busy | output | 1 | Capture armed or in progress |
| overflow | output | 1 | Sticky: an entry was dropped |

## Verification
A wrong bunch counter or a misaligned start shows up in the index field of the first word read out, and in the sample values paired with each index. Both are visible within one turn of the trigger. A fault in the pedestal, cut or reduction logic corrupts `liveOut` one clock after the offending crossing. Sweeping samples around the baseline, at the threshold edge and above the saturation point exposes such a fault within a few crossings. Faults in the arming, busy or overflow state show up as a wrong entry count, a missing or extra last flag, or a flag level that is wrong once the turn ends.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int SAMPLE_W = 12;
  localparam int IDX_W    = 12;
  localparam int WORD_W   = 16;
  localparam int LO_W     = 8;
  localparam int HI_W     = SAMPLE_W - LO_W;
  localparam int FLAG_W   = WORD_W - LO_W;
  localparam int LIVE_W   = 8;
  localparam int NARROW_W = 4;

  typedef struct packed {
    logic capture;
    logic first;
    logic last;
    logic clearOvf;
  } tic_strobe_t;

  typedef struct packed {
    logic [IDX_W-1:0]    idx;
    logic [SAMPLE_W-1:0] val;
    logic                first;
    logic                last;
    logic                supp;
  } tic_entry_t;

  localparam int ENTRY_W = $bits(tic_entry_t);
endpackage

// File: rtl/tic_control.sv
module tic_control
  import tic_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             orbitIn,
  input  logic             trigIn,
  input  logic [IDX_W-1:0] turnLen,
  output logic [IDX_W-1:0] curIdx,
  output tic_strobe_t      strobes,
  output logic             armed
);
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} state_t;

  state_t           state;
  logic [IDX_W-1:0] bxCnt;
  logic             lastOfTurn;
  logic             startNow;

  assign curIdx     = orbitIn ? '0 : bxCnt;
  assign lastOfTurn = (curIdx >= turnLen - 1'b1);
  assign startNow   = (state == ST_ARMED) && orbitIn;

  always_comb begin
    strobes.capture  = startNow || (state == ST_RUN);
    strobes.first    = startNow;
    strobes.last     = strobes.capture && lastOfTurn;
    strobes.clearOvf = (state == ST_IDLE) && trigIn;
  end

  assign armed = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bxCnt <= '0;
    end else if (lastOfTurn) begin
      bxCnt <= '0;
    end else begin
      bxCnt <= curIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  if (trigIn) state <= ST_ARMED;
        ST_ARMED: if (orbitIn) state <= lastOfTurn ? ST_IDLE : ST_RUN;
        ST_RUN:   if (lastOfTurn) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tic_datapath.sv
module tic_datapath
  import tic_pkg::*;
#(
  parameter int LIVE_WIN = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [SAMPLE_W-1:0] baseline,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic                liveNarrow,
  input  logic [IDX_W-1:0]    curIdx,
  input  tic_strobe_t         strobes,
  output logic [LIVE_W-1:0]   liveOut,
  output logic                wrEn,
  output tic_entry_t          entry
);
  logic [SAMPLE_W-1:0] diff;
  logic                above;
  logic                belowCut;
  logic [SAMPLE_W-1:0] corr;
  logic [SAMPLE_W-1:0] corrReg;
  logic                overRange;
  logic [LIVE_W-1:0]   wideVal;
  logic [NARROW_W-1:0] narrowVal;

  assign above    = sampleIn > baseline;
  assign diff     = above ? (sampleIn - baseline) : '0;
  assign belowCut = diff < threshold;
  assign corr     = belowCut ? '0 : diff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      corrReg <= '0;
      wrEn    <= 1'b0;
      entry   <= '0;
    end else begin
      corrReg     <= corr;
      wrEn        <= strobes.capture;
      entry.idx   <= curIdx;
      entry.val   <= corr;
      entry.first <= strobes.first;
      entry.last  <= strobes.last;
      entry.supp  <= above && belowCut;
    end
  end

  generate
    if (LIVE_WIN < SAMPLE_W) begin : g_sat
      assign overRange = |corrReg[SAMPLE_W-1:LIVE_WIN];
    end else begin : g_nosat
      assign overRange = 1'b0;
    end
  endgenerate

  assign wideVal   = overRange ? '1 : corrReg[LIVE_WIN-1 -: LIVE_W];
  assign narrowVal = overRange ? '1 : corrReg[LIVE_WIN-1 -: NARROW_W];
  assign liveOut   = liveNarrow ? {{(LIVE_W-NARROW_W){1'b0}}, narrowVal} : wideVal;
endmodule

// File: rtl/tic_fifo.sv
module tic_fifo
  import tic_pkg::*;
#(
  parameter int DEPTH = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  tic_entry_t        wrEntry,
  input  logic              clearOvf,
  input  logic              rdWord,
  output logic [WORD_W-1:0] rdData,
  output logic              empty,
  output logic              overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [CNT_W-1:0]   count;
  logic               half;
  logic               full;
  logic               push;
  logic               pop;
  tic_entry_t         head;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign push  = wrEn && !full;
  assign pop   = rdWord && !empty && half;
  assign head  = tic_entry_t'(mem[rdPtr]);

  always_comb begin
    if (empty) begin
      rdData = '0;
    end else if (!half) begin
      rdData = {head.idx, head.val[SAMPLE_W-1 -: HI_W]};
    end else begin
      rdData = {head.first, head.last, head.supp, {(FLAG_W-3){1'b0}},
                head.val[LO_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      half     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (rdWord && !empty) half <= ~half;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wrEn && full)  overflow <= 1'b1;
      else if (clearOvf) overflow <= 1'b0;
    end
  end
endmodule

// File: rtl/turn_intensity_capture.sv
module turn_intensity_capture
  import tic_pkg::*;
#(
  parameter int FIFO_DEPTH = 4096,
  parameter int LIVE_WIN   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                orbitIn,
  input  logic                trigIn,
  input  logic [IDX_W-1:0]    turnLen,
  input  logic [SAMPLE_W-1:0] baseline,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic                liveNarrow,
  output logic [LIVE_W-1:0]   liveOut,
  input  logic                fifoRd,
  output logic [WORD_W-1:0]   fifoData,
  output logic                fifoEmpty,
  output logic                busy,
  output logic                overflow
);
  tic_strobe_t      strobes;
  tic_entry_t       entry;
  logic [IDX_W-1:0] curIdx;
  logic             armed;
  logic             wrEn;

  tic_control i_control (
    .clk(clk), .rstN(rstN), .orbitIn(orbitIn), .trigIn(trigIn),
    .turnLen(turnLen), .curIdx(curIdx), .strobes(strobes), .armed(armed)
  );

  tic_datapath #(.LIVE_WIN(LIVE_WIN)) i_datapath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .baseline(baseline),
    .threshold(threshold), .liveNarrow(liveNarrow), .curIdx(curIdx),
    .strobes(strobes), .liveOut(liveOut), .wrEn(wrEn), .entry(entry)
  );

  tic_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrEntry(entry),
    .clearOvf(strobes.clearOvf), .rdWord(fifoRd), .rdData(fifoData),
    .empty(fifoEmpty), .overflow(overflow)
  );

  assign busy = armed || wrEn;
endmodule

// File: rtl/tic_checker.sv
module tic_checker (
  input logic        clk,
  input logic        rstN,
  input logic        orbitIn,
  input logic        trigIn,
  input logic [11:0] turnLen,
  input logic [11:0] curIdx,
  input logic        busy,
  input logic        overflow,
  input logic        fifoEmpty,
  input logic        wrEn,
  input logic        liveNarrow,
  input logic [7:0]  liveOut
);
  assert_idx_one_after_orbit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (orbitIn && turnLen > 12'd1) ##1 !orbitIn |-> curIdx == 12'd1);

  assert_busy_on_trig_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && trigIn) |=> busy);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !trigIn) |=> overflow);

  assert_empty_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && !wrEn) |=> fifoEmpty);

  assert_narrow_top_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    liveNarrow |-> liveOut[7:4] == 4'd0);
endmodule

bind turn_intensity_capture tic_checker i_tic_checker (
  .clk(clk), .rstN(rstN), .orbitIn(orbitIn), .trigIn(trigIn),
  .turnLen(turnLen), .curIdx(curIdx), .busy(busy), .overflow(overflow),
  .fifoEmpty(fifoEmpty), .wrEn(wrEn), .liveNarrow(liveNarrow),
  .liveOut(liveOut)
);

// File: tb/test_turn_intensity_capture.sv
`timescale 1ns/1ps
module test_turn_intensity_capture;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] sampleIn = '0;
  logic        orbitIn = 1'b0;
  logic        trigIn = 1'b0;
  logic [11:0] turnLen = 12'd20;
  logic [11:0] baseline = 12'd300;
  logic [11:0] threshold = 12'd20;
  logic        liveNarrow = 1'b0;
  logic [7:0]  liveOut;
  logic        fifoRd = 1'b0;
  logic [15:0] fifoData;
  logic        fifoEmpty;
  logic        busy;
  logic        overflow;

  turn_intensity_capture #(.FIFO_DEPTH(DEPTH)) i_turn_intensity_capture (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .orbitIn(orbitIn),
    .trigIn(trigIn), .turnLen(turnLen), .baseline(baseline),
    .threshold(threshold), .liveNarrow(liveNarrow), .liveOut(liveOut),
    .fifoRd(fifoRd), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .busy(busy), .overflow(overflow)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int genRun = 0;
  int tl = 20;
  int capLen = 20;
  int benchIdx = 19;
  int seq = 0;
  int recState = 0;
  int reqTrig = 0;
  int prevValid = 0;
  int prevS = 0;
  int expS [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int corrOf(input int s);
    int d;
    d = (s > baseline) ? s - baseline : 0;
    if (d < threshold) d = 0;
    return d;
  endfunction

  function automatic int liveOf(input int c, input bit narrow);
    if (narrow) return (c >= 1024) ? 15 : (c >> 6) & 15;
    return (c >= 1024) ? 255 : (c >> 2) & 255;
  endfunction

  function automatic int pat(input int n);
    if (n % 2) return (n * 173) % 4096;
    return baseline + ((n / 2) % 48) - 16;
  endfunction

  always @(negedge clk) begin
    if (genRun != 0) begin
      if (prevValid != 0)
        chk(liveOut == 8'(liveOf(corrOf(prevS), liveNarrow)), "R2/R3 live",
            liveOut, liveOf(corrOf(prevS), liveNarrow));
      benchIdx = (benchIdx >= tl - 1) ? 0 : benchIdx + 1;
      seq++;
      prevS = pat(seq);
      sampleIn = 12'(prevS);
      orbitIn = (benchIdx == 0);
      if (recState == 1 && benchIdx == 0) recState = 2;
      if (recState == 2 && benchIdx < capLen) begin
        expS[benchIdx] = prevS;
        if (benchIdx == capLen - 1) recState = 3;
      end
      if (reqTrig != 0) begin
        trigIn = 1'b1;
        reqTrig = 0;
        if (recState == 0 || recState == 3) recState = 1;
      end else begin
        trigIn = 1'b0;
      end
      prevValid = 1;
    end else begin
      orbitIn = 1'b0;
      trigIn = 1'b0;
      prevValid = 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitIdx(input int k);
    while (benchIdx != k) cyc(1);
  endtask

  task automatic startGen(input int newTl, input int newCap, input int newLen);
    genRun = 0;
    cyc(2);
    tl = newTl;
    capLen = newCap;
    turnLen = 12'(newLen);
    benchIdx = newTl - 1;
    recState = 0;
    genRun = 1;
  endtask

  task automatic readTurn(input int n);
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk(!busy, "R7 busy falls", busy, 0);
    for (int e = 0; e < n; e++) begin
      int v = corrOf(expS[e]);
      int s = expS[e];
      bit supp = (s > baseline) && ((s - baseline) < threshold);
      int wa = (e << 4) | ((v >> 8) & 15);
      int wb = ((e == 0) << 15) | ((e == capLen - 1) << 14) | (supp << 13) | (v & 255);
      if (e > 0) @(negedge clk);
      chk(fifoData == 16'(wa), "R5/R6 word A", fifoData, wa);
      fifoRd = 1'b1;
      @(negedge clk);
      chk(fifoData == 16'(wb), "R6 word B", fifoData, wb);
    end
    @(negedge clk);
    fifoRd = 1'b0;
    chk(fifoEmpty, "R5/R9 empty after turn", fifoEmpty, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cyc(5);
    rstN = 1'b1;
    @(negedge clk);
    chk(liveOut == 8'd0, "R10 liveOut", liveOut, 0);
    chk(!busy, "R10 busy", busy, 0);
    chk(!overflow, "R10 overflow", overflow, 0);
    chk(fifoEmpty, "R10 fifoEmpty", fifoEmpty, 1);

    fifoRd = 1'b1;
    repeat (3) @(negedge clk);
    fifoRd = 1'b0;
    @(negedge clk);
    chk(fifoEmpty, "R9 read while empty", fifoEmpty, 1);

    // Phase A: wide live word, trigger mid-turn, one full turn
    startGen(20, 20, 20);
    cyc(60);
    waitIdx(7);
    reqTrig = 1;
    @(negedge clk);
    @(negedge clk);
    chk(busy, "R4 busy after trigger", busy, 1);
    readTurn(20);
    chk(!overflow, "R8 no overflow", overflow, 0);

    // Phase B: narrow live word, higher cut, shorter turn, trigger at orbit
    genRun = 0;
    cyc(2);
    liveNarrow = 1'b1;
    threshold = 12'd60;
    startGen(20, 12, 12);
    cyc(45);
    waitIdx(19);
    reqTrig = 1;
    while (!(recState == 2 && benchIdx == 3)) cyc(1);
    reqTrig = 1;
    readTurn(12);
    cyc(30);
    chk(!busy, "R7 trigger while running ignored", busy, 0);
    chk(fifoEmpty, "R1/R7 no extra entries", fifoEmpty, 1);

    // Phase C: turn longer than the FIFO
    genRun = 0;
    cyc(2);
    liveNarrow = 1'b0;
    threshold = 12'd20;
    startGen(40, 40, 40);
    cyc(50);
    waitIdx(5);
    reqTrig = 1;
    cyc(90);
    while (busy) cyc(1);
    @(negedge clk);
    chk(overflow, "R8 overflow set", overflow, 1);
    readTurn(DEPTH);
    cyc(1);
    reqTrig = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!overflow, "R8 overflow cleared by trigger", overflow, 0);

    genRun = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule